// File: doc/BRIEF.md
# Tiled Wide Unsigned Multiplier

This block multiplies two unsigned operands that are each too wide for one fixed hard multiplier tile. It splits every operand once into a low part and a high part, forms the four cross products on four copies of the tile, and merges them with a small adder network. The result is the product kept to a chosen output width.

The tile may have unequal port sizes. The block first decides which tile port faces which operand so that both high parts fit. When the two port sizes are equal, it uses a two-adder chain, and the lowest tile-width bits go straight from the low-by-low product to the output. When the port sizes differ, it uses three adders instead: one adds the two shifted middle products, one joins the outer products, and a last adder adds those two sums. The block is purely combinational and has no clock.

The variant is chosen at elaboration time from the parameters. There is no state machine. A legal configuration needs each split point below its operand width and each high part no wider than its tile port.

Top module: `wide_mul_tiled`

## Requirements
- R1: `prod_o` equals (`a_i` × `b_i`) mod 2^P_W for every pair of operands, in both the equal-tile and the unequal-tile configuration.
- R2: The split points are ka (bits of `a_i` per low part) and kb (bits of `b_i` per low part). Each high part is zero-extended to its tile port width, so the high-by-low product never has a bit set at or above position (A_W−ka)+kb.
- R3: Orientation rule. The default is ka = TILE_X and kb = TILE_Y. The two are swapped when the default would leave a high part wider than its tile port. With A_W=30, B_W=40 and a 25×18 tile, this gives ka=18 and kb=25, and all-ones operands still produce the correct product.
- R4: Unequal tiles, first adder. It adds (high-a × low-b) shifted left by ka and (low-a × high-b) shifted left by kb, with one spare top bit. The sum never wraps.
- R5: Unequal tiles, second adder. It adds the high-by-high product shifted left by ka+kb and the low-by-low product. Its lower ka+kb bits equal the low-by-low product, its upper bits equal the high-by-high product, and no carry crosses between them.
- R6: Unequal tiles, third adder. Any carry above P_W is dropped. For example, 2^29 × 2^39 with P_W=64 gives 0, and all-ones operands give the low 64 bits of the full product.
- R7: Equal tiles. The lowest kb bits of `prod_o` equal the lowest kb bits of (low-a × low-b).
- R8: Equal tiles, two-adder chain. Bits kb and above equal the sum of two terms: (high-a × low-b) + (low-a × high-b), and the upper half of the low-by-low product concatenated below the high-by-high product. Products whose middle terms carry are still exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | A_W | first unsigned operand |
| b_i | input | B_W | second unsigned operand |
| prod_o | output | P_W | product, truncated to P_W bits |

## Verification
Inline immediate assertions check several properties whenever the operands change:
- the zero-extended high-by-low product stays inside its real width;
- the first adder of the unequal path does not wrap;
- the outer-product adder keeps its two terms apart;
- the bypassed low bits of the equal path match the low operand slices;
- the least significant product bit is the AND of the operand LSBs.

Only the bench scenarios can show the rest:
- that the whole product is right;
- that the orientation swap is needed for all-ones operands;
- that truncation drops exactly the bits above P_W.

The bench covers both the asymmetric and the square tile configuration.

// File: rtl/wide_mul_pkg.sv
package wide_mul_pkg;

    // Decide whether the tile ports must face the operands the other way round.
    function automatic bit tile_swap(input int aw, input int bw, input int tx, input int ty);
        return !((aw <= 2 * tx) && (bw <= 2 * ty));
    endfunction

    function automatic int imax(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/mul_tile.sv
module mul_tile #(
    parameter int WA = 18,
    parameter int WB = 25
) (
    input  logic [WA-1:0]    x_i,
    input  logic [WB-1:0]    y_i,
    output logic [WA+WB-1:0] p_o
);
    localparam int PW = WA + WB;

    assign p_o = PW'(x_i) * PW'(y_i);

endmodule

// File: rtl/merge_square.sv
module merge_square #(
    parameter int T   = 16,
    parameter int P_W = 40
) (
    input  logic [2*T-1:0] pp_ll_i,
    input  logic [2*T-1:0] pp_hl_i,
    input  logic [2*T-1:0] pp_lh_i,
    input  logic [2*T-1:0] pp_hh_i,
    output logic [P_W-1:0] prod_o
);
    import wide_mul_pkg::*;

    localparam int MW = 2 * T + 1;
    localparam int UW = 3 * T;
    localparam int FW = 4 * T;
    localparam int WX = imax(FW, P_W);

    logic [MW-1:0] mid;
    logic [UW-1:0] upper;
    logic [UW-1:0] hi;
    logic [FW-1:0] full;
    logic [WX-1:0] wide;

    assign mid   = MW'(pp_hl_i) + MW'(pp_lh_i);
    assign upper = {pp_hh_i, pp_ll_i[2*T-1:T]};
    assign hi    = UW'(mid) + upper;
    assign full  = {hi, pp_ll_i[T-1:0]};
    assign wide  = WX'(full);
    assign prod_o = wide[P_W-1:0];

    // R8
    always_comb begin
        if (!$isunknown({pp_hl_i, pp_lh_i})) begin
            mid_nowrap_chk: assert (mid >= MW'(pp_hl_i) && mid >= MW'(pp_lh_i));
        end
    end

endmodule

// File: rtl/merge_skewed.sv
module merge_skewed #(
    parameter int KA  = 18,
    parameter int KB  = 25,
    parameter int P_W = 64
) (
    input  logic [KA+KB-1:0] pp_ll_i,
    input  logic [KA+KB-1:0] pp_hl_i,
    input  logic [KA+KB-1:0] pp_lh_i,
    input  logic [KA+KB-1:0] pp_hh_i,
    output logic [P_W-1:0]   prod_o
);
    import wide_mul_pkg::*;

    localparam int PPW = KA + KB;
    localparam int W1  = PPW + imax(KA, KB) + 1;
    localparam int W2  = 2 * PPW;
    localparam int WX  = imax(W2, P_W);

    logic [W1-1:0] cross_sum;
    logic [W2-1:0] outer_sum;
    logic [WX-1:0] total;

    assign cross_sum = (W1'(pp_hl_i) << KA) + (W1'(pp_lh_i) << KB);
    assign outer_sum = (W2'(pp_hh_i) << PPW) + W2'(pp_ll_i);
    assign total     = WX'(cross_sum) + WX'(outer_sum);
    assign prod_o    = total[P_W-1:0];

    // R4
    always_comb begin
        if (!$isunknown({pp_hl_i, pp_lh_i})) begin
            cross_nowrap_chk: assert (cross_sum >= (W1'(pp_hl_i) << KA)
                                      && cross_sum >= (W1'(pp_lh_i) << KB));
        end
    end

    // R5
    always_comb begin
        if (!$isunknown({pp_hh_i, pp_ll_i})) begin
            outer_disjoint_chk: assert (outer_sum[PPW-1:0] == pp_ll_i
                                        && outer_sum[W2-1:PPW] == pp_hh_i);
        end
    end

endmodule

// File: rtl/wide_mul_tiled.sv
module wide_mul_tiled #(
    parameter int A_W    = 30,
    parameter int B_W    = 40,
    parameter int TILE_X = 25,
    parameter int TILE_Y = 18,
    parameter int P_W    = 64
) (
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic [P_W-1:0] prod_o
);
    import wide_mul_pkg::*;

    localparam bit SWAP = tile_swap(A_W, B_W, TILE_X, TILE_Y);
    localparam int KA   = SWAP ? TILE_Y : TILE_X;
    localparam int KB   = SWAP ? TILE_X : TILE_Y;
    localparam int PPW  = KA + KB;
    localparam int HA_W = A_W - KA;
    localparam int HB_W = B_W - KB;

    logic [KA-1:0]  a_lo, a_hi;
    logic [KB-1:0]  b_lo, b_hi;
    logic [PPW-1:0] pp_ll, pp_hl, pp_lh, pp_hh;

    assign a_lo = a_i[KA-1:0];
    assign b_lo = b_i[KB-1:0];
    assign a_hi = KA'(a_i >> KA);
    assign b_hi = KB'(b_i >> KB);

    mul_tile #(.WA(KA), .WB(KB)) t_ll_i (.x_i(a_lo), .y_i(b_lo), .p_o(pp_ll));
    mul_tile #(.WA(KA), .WB(KB)) t_hl_i (.x_i(a_hi), .y_i(b_lo), .p_o(pp_hl));
    mul_tile #(.WA(KA), .WB(KB)) t_lh_i (.x_i(a_lo), .y_i(b_hi), .p_o(pp_lh));
    mul_tile #(.WA(KA), .WB(KB)) t_hh_i (.x_i(a_hi), .y_i(b_hi), .p_o(pp_hh));

    generate
        if (KA == KB) begin : g_square
            merge_square #(.T(KA), .P_W(P_W)) merge_i (
                .pp_ll_i(pp_ll), .pp_hl_i(pp_hl), .pp_lh_i(pp_lh),
                .pp_hh_i(pp_hh), .prod_o(prod_o)
            );

            // R7
            always_comb begin
                if (!$isunknown({a_i, b_i})) begin
                    low_bypass_chk: assert (prod_o[KB-1:0]
                        == KB'((PPW)'(a_i[KA-1:0]) * (PPW)'(b_i[KB-1:0])));
                end
            end
        end else begin : g_skewed
            merge_skewed #(.KA(KA), .KB(KB), .P_W(P_W)) merge_i (
                .pp_ll_i(pp_ll), .pp_hl_i(pp_hl), .pp_lh_i(pp_lh),
                .pp_hh_i(pp_hh), .prod_o(prod_o)
            );
        end
    endgenerate

    // R2
    always_comb begin
        if (!$isunknown(a_i)) begin
            hi_width_chk: assert ((pp_hl >> (HA_W + KB)) == '0);
        end
    end

    // R1
    always_comb begin
        if (!$isunknown({a_i, b_i})) begin
            lsb_chk: assert (prod_o[0] == (a_i[0] & b_i[0]));
        end
    end

endmodule

// File: tb/wide_mul_tiled_tb.sv
`timescale 1ns/1ps
module wide_mul_tiled_tb_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    bit   done = 1'b0;
    int   n_chk = 0;
    int   n_bad = 0;

    // asymmetric 25x18 tile, swapped orientation
    logic [29:0] ua;
    logic [39:0] ub;
    logic [63:0] uprod;
    // square 16x16 tile
    logic [23:0] ea;
    logic [19:0] eb;
    logic [39:0] eprod;

    wide_mul_tiled dut_i (.a_i(ua), .b_i(ub), .prod_o(uprod));

    wide_mul_tiled #(.A_W(24), .B_W(20), .TILE_X(16), .TILE_Y(16), .P_W(40))
        dut_eq_i (.a_i(ea), .b_i(eb), .prod_o(eprod));

    localparam int NV = 6;
    localparam logic [29:0] VA [NV] = '{30'h0000_1234, 30'h2AAA_AAAA, 30'h0003_FFFF,
                                        30'h1555_0001, 30'h3FFF_FFFF, 30'h0004_0000};
    localparam logic [39:0] VB [NV] = '{40'h00_0000_5678, 40'h55_5555_5555, 40'hFF_FE00_0000,
                                        40'h01_FFFF_FFFF, 40'h00_0000_0001, 40'h80_0000_0000};

    task automatic report(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_u(input string tag, input logic [29:0] a, input logic [39:0] b);
        logic [69:0] ref_p;
        @(posedge clk);
        ua = a;
        ub = b;
        @(negedge clk);
        ref_p = 70'(a) * 70'(b);
        report(tag, uprod, ref_p[63:0]);
    endtask

    task automatic run_e(input string tag, input logic [23:0] a, input logic [19:0] b);
        logic [43:0] ref_p;
        @(posedge clk);
        ea = a;
        eb = b;
        @(negedge clk);
        ref_p = 44'(a) * 44'(b);
        report(tag, 64'(eprod), 64'(ref_p[39:0]));
        report({tag, " R7 low bits"}, 64'(eprod[15:0]), 64'(ref_p[15:0]));
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 1'b0;
        ua = '0; ub = '0; ea = '0; eb = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 zero operands after reset give zero
        report("R1 reset zero unequal", uprod, 64'h0);
        report("R1 reset zero equal", 64'(eprod), 64'h0);

        // R1 R4 R5 vector table through the asymmetric tile
        for (int i = 0; i < NV; i++) begin
            run_u("R1 R4 R5 table", VA[i], VB[i]);
        end

        // R3 all-ones needs the swapped orientation; R6 truncation of the top bits
        run_u("R3 R6 all ones", 30'h3FFF_FFFF, 40'hFF_FFFF_FFFF);
        // R6 single top bits: 2^68 drops out of a 64-bit result
        run_u("R6 top bits vanish", 30'h2000_0000, 40'h80_0000_0000);
        // R2 single bits at the split points
        run_u("R2 split bit a", 30'h0002_0000, 40'h00_0100_0000);
        run_u("R2 high-part bit", 30'h0004_0000, 40'h00_0200_0000);

        // R7 R8 square tile: corners and carries in the middle terms
        run_e("R8 all ones", 24'hFF_FFFF, 20'hF_FFFF);
        run_e("R8 mid carry", 24'hFF_FFFF, 20'h0_FFFF);
        run_e("R7 single bit", 24'h00_0001, 20'h1_0000);
        run_e("R8 high only", 24'hFF_0000, 20'hF_0000);

        // R1 random operands on both configurations
        for (int k = 0; k < 40; k++) begin
            run_u("R1 random unequal", 30'($urandom), {8'($urandom), 32'($urandom)});
            run_e("R1 random equal", 24'($urandom), 20'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule